// File: doc/BRIEF.md
# Gated Frequency Counting Core

This core measures the rate of a pre-synchronized edge stream by counting those edges over a gate window of selectable length. A free-running divider splits the system clock into timebase ticks. Every gate length is a whole number of ticks. The edge counter is never cleared. At gate open and at gate close it is sampled, and the result is the close sample minus the open sample, truncated to 32 bits.

The counter has three sections. The low section is a short fast stage followed by a 16-bit middle counter. When the middle counter wraps, it sets a sticky overflow flag and raises nothing else. The flag is polled and cleared on each timebase tick. Each poll that finds the flag set advances an extension made of 8-bit registers. The first stage counts only while a complementary enable pair is active. One line of the pair is active high and the other active low, and both change together.

Two inputs choose the gate. `res_sel` picks one of three lengths. `pre_mode` says whether an external divide-by-64 prescaler sits in front of the input, and selects a second set of lengths. Gates run back to back: the tick that closes one gate opens the next. If the configuration changes while a gate is open, that gate is dropped and a new one opens on the next tick. The controller has three states:

- IDLE: after reset.
- GATE: measuring.
- WAIT: after an abort.

It has four transitions:

- OPEN: IDLE to GATE on a tick.
- CLOSE: GATE to GATE on the final tick of a gate, which publishes a result.
- ABORT: GATE to WAIT on a configuration change.
- REOPEN: WAIT to GATE on a tick.

Top module: `freq_gate_core`

## Requirements
- R1: A timebase tick occurs once every CLK_PER_TICK clocks. With a steady configuration, successive `result_valid` pulses are exactly gate_ticks × CLK_PER_TICK clocks apart (2000 clocks per tick by default).
- R2: With `pre_mode`=0, `res_sel` values 0, 1 and 2 give gates of DIR_LEN0, DIR_LEN1 and DIR_LEN2 ticks (1000, 10000 and 100000 by default).
- R3: With `pre_mode`=1, `res_sel` values 0, 1 and 2 give gates of PRE_LEN0, PRE_LEN1 and PRE_LEN2 ticks (640, 6400 and 64000 by default).
- R4: `res_sel`=3 behaves exactly like `res_sel`=2 in both modes.
- R5: `result` equals, modulo 2^32, the number of clock cycles with `edge_in` high. The cycles counted run from the opening tick's cycle up to, but not including, the closing tick's cycle. The first stage counts only while its enable pair is active (true line 1, inverted line 0), and the two lines are always complements.
- R6: A middle-counter wrap sets a sticky flag that the next tick clears while advancing the extension. Results whose gates span one or more low-section wraps are still exact. At most one wrap occurs between polls.
- R7: `result_valid` is high for exactly one clock, on the cycle after the closing tick. `result` changes only on that cycle and otherwise holds its value.
- R8: The closing tick of a gate opens the next gate at once. Under continuous input no edge is lost and none is counted twice across consecutive gates.
- R9: A change of `res_sel` or `pre_mode` while a gate is open discards that gate without a pulse. A new gate using the new setting opens on the next tick.
- R10: While `rst_n` is low, `result` is 0 and `result_valid` is 0. The first gate opens on the first tick after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| edge_in | input | 1 | Synchronized edge strobe; one counted edge per high cycle |
| res_sel | input | 2 | Gate length select (3 aliases 2) |
| pre_mode | input | 1 | 1 selects the gate lengths for prescaled input |
| result | output | 32 | Last completed count difference |
| result_valid | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The assertions take for granted that `edge_in` carries at most one edge per clock. They also assume the edge rate per tick is low enough that the middle counter cannot wrap twice between polls. With CLK_PER_TICK above one, tick pulses and valid pulses are each a single cycle wide. The stimulus shrinks the tick and the low section, so that wraps and gate closings happen often. It still drives at most one edge per clock, far fewer than one wrap's worth of edges per tick. Configuration changes are made on clock boundaries and include deliberate aborts in the middle of a gate.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_GATE = 2'd1,
        S_WAIT = 2'd2
    } gate_state_e;

    typedef struct packed {
        logic       pre;
        logic [1:0] sel;
    } gate_cfg_t;

endpackage

// File: rtl/fgc_timebase.sv
module fgc_timebase #(
    parameter int unsigned CLK_PER_TICK = 2000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

    logic [CW-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/fgc_edge_counter.sv
module fgc_edge_counter #(
    parameter int unsigned FAST_W    = 4,
    parameter int unsigned MID_W     = 16,
    parameter int unsigned EXT_BYTES = 2,
    parameter int unsigned OUT_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_j,
    input  logic             en_kn,
    input  logic             edge_in,
    input  logic             poll,
    output logic [OUT_W-1:0] count_now
);
    localparam int unsigned EXT_W = 8 * EXT_BYTES;

    logic [FAST_W-1:0]    fast_q;
    logic [MID_W-1:0]     mid_q;
    logic                 ovf_q;
    logic                 step;
    logic                 fast_carry;
    logic                 mid_wrap;
    logic [EXT_BYTES-1:0] carry;
    logic [EXT_W-1:0]     ext_flat;
    logic [EXT_W-1:0]     ext_sum;

    // J high with inverted K low means toggle; any other pair holds
    assign step       = en_j & ~en_kn & edge_in;
    assign fast_carry = step & (&fast_q);
    assign mid_wrap   = fast_carry & (&mid_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_q <= '0;
        end else if (step) begin
            fast_q <= fast_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mid_q <= '0;
        end else if (fast_carry) begin
            mid_q <= mid_q + 1'b1;
        end
    end

    // sticky wrap flag, cleared only by the tick poll
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= mid_wrap | (ovf_q & ~poll);
        end
    end

    assign carry[0] = poll & ovf_q;

    for (genvar b = 0; b < EXT_BYTES; b++) begin : g_ext
        logic [7:0] byte_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (carry[b]) begin
                byte_q <= byte_q + 1'b1;
            end
        end

        assign ext_flat[8*b +: 8] = byte_q;

        if (b < EXT_BYTES - 1) begin : g_ripple
            assign carry[b+1] = carry[b] & (&byte_q);
        end
    end

    // a pending, not yet polled wrap is folded into the sampled value
    assign ext_sum   = ext_flat + EXT_W'(ovf_q);
    assign count_now = OUT_W'({ext_sum, mid_q, fast_q});
endmodule

// File: rtl/fgc_gate_fsm.sv
module fgc_gate_fsm
    import fgc_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned DIR_LEN0 = 1000,
    parameter int unsigned DIR_LEN1 = 10000,
    parameter int unsigned DIR_LEN2 = 100000,
    parameter int unsigned PRE_LEN0 = 640,
    parameter int unsigned PRE_LEN1 = 6400,
    parameter int unsigned PRE_LEN2 = 64000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  gate_cfg_t        cfg_in,
    input  logic [CNT_W-1:0] count_now,
    output logic             en_j,
    output logic             en_kn,
    output logic [CNT_W-1:0] result,
    output logic             valid
);
    localparam int unsigned MAX_D   = (DIR_LEN0 > DIR_LEN1) ?
                                      ((DIR_LEN0 > DIR_LEN2) ? DIR_LEN0 : DIR_LEN2) :
                                      ((DIR_LEN1 > DIR_LEN2) ? DIR_LEN1 : DIR_LEN2);
    localparam int unsigned MAX_P   = (PRE_LEN0 > PRE_LEN1) ?
                                      ((PRE_LEN0 > PRE_LEN2) ? PRE_LEN0 : PRE_LEN2) :
                                      ((PRE_LEN1 > PRE_LEN2) ? PRE_LEN1 : PRE_LEN2);
    localparam int unsigned MAX_LEN = (MAX_D > MAX_P) ? MAX_D : MAX_P;
    localparam int unsigned TICK_W  = $clog2(MAX_LEN + 1);

    gate_state_e      state_q, state_d;
    gate_cfg_t        cfg_q;
    logic [TICK_W-1:0] tk_q;
    logic [TICK_W-1:0] gate_len;
    logic [CNT_W-1:0]  start_q;
    logic              cfg_changed;
    logic              last_tick;

    always_comb begin
        case ({cfg_q.pre, cfg_q.sel})
            3'b000:          gate_len = TICK_W'(DIR_LEN0);
            3'b001:          gate_len = TICK_W'(DIR_LEN1);
            3'b010, 3'b011:  gate_len = TICK_W'(DIR_LEN2);
            3'b100:          gate_len = TICK_W'(PRE_LEN0);
            3'b101:          gate_len = TICK_W'(PRE_LEN1);
            default:         gate_len = TICK_W'(PRE_LEN2);
        endcase
    end

    assign cfg_changed = (cfg_in != cfg_q);
    assign last_tick   = tick && (tk_q == gate_len - 1'b1);

    // next state: OPEN, CLOSE, ABORT, REOPEN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (tick) state_d = S_GATE;
            S_WAIT:  if (tick) state_d = S_GATE;
            S_GATE:  if (cfg_changed) state_d = S_WAIT;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_j    <= 1'b0;
            en_kn   <= 1'b1;
            valid   <= 1'b0;
            result  <= '0;
            start_q <= '0;
            cfg_q   <= '0;
            tk_q    <= '0;
        end else begin
            en_j  <= 1'b1;
            en_kn <= 1'b0;
            valid <= 1'b0;
            unique case (state_q)
                S_IDLE, S_WAIT: begin
                    if (tick) begin
                        start_q <= count_now;
                        cfg_q   <= cfg_in;
                        tk_q    <= '0;
                    end
                end
                S_GATE: begin
                    if (!cfg_changed && tick) begin
                        if (last_tick) begin
                            result  <= count_now - start_q;
                            valid   <= 1'b1;
                            start_q <= count_now;
                            tk_q    <= '0;
                        end else begin
                            tk_q <= tk_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/freq_gate_core.sv
module freq_gate_core
    import fgc_pkg::*;
#(
    parameter int unsigned CLK_PER_TICK = 2000,
    parameter int unsigned FAST_W       = 4,
    parameter int unsigned MID_W        = 16,
    parameter int unsigned EXT_BYTES    = 2,
    parameter int unsigned RES_W        = 32,
    parameter int unsigned DIR_LEN0     = 1000,
    parameter int unsigned DIR_LEN1     = 10000,
    parameter int unsigned DIR_LEN2     = 100000,
    parameter int unsigned PRE_LEN0     = 640,
    parameter int unsigned PRE_LEN1     = 6400,
    parameter int unsigned PRE_LEN2     = 64000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_in,
    input  logic [1:0]       res_sel,
    input  logic             pre_mode,
    output logic [RES_W-1:0] result,
    output logic             result_valid
);
    logic             tick;
    logic             cnt_j;
    logic             cnt_kn;
    logic [RES_W-1:0] count_now;
    gate_cfg_t        cfg_in;

    assign cfg_in.pre = pre_mode;
    assign cfg_in.sel = res_sel;

    fgc_timebase #(
        .CLK_PER_TICK(CLK_PER_TICK)
    ) u_tb (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    fgc_edge_counter #(
        .FAST_W   (FAST_W),
        .MID_W    (MID_W),
        .EXT_BYTES(EXT_BYTES),
        .OUT_W    (RES_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_j     (cnt_j),
        .en_kn    (cnt_kn),
        .edge_in  (edge_in),
        .poll     (tick),
        .count_now(count_now)
    );

    fgc_gate_fsm #(
        .CNT_W   (RES_W),
        .DIR_LEN0(DIR_LEN0),
        .DIR_LEN1(DIR_LEN1),
        .DIR_LEN2(DIR_LEN2),
        .PRE_LEN0(PRE_LEN0),
        .PRE_LEN1(PRE_LEN1),
        .PRE_LEN2(PRE_LEN2)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cfg_in   (cfg_in),
        .count_now(count_now),
        .en_j     (cnt_j),
        .en_kn    (cnt_kn),
        .result   (result),
        .valid    (result_valid)
    );
endmodule

// File: rtl/fgc_checker.sv
module fgc_checker #(
    parameter int unsigned RES_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             mid_wrap,
    input logic             ovf_flag,
    input logic             cnt_j,
    input logic             cnt_kn,
    input logic             valid,
    input logic [RES_W-1:0] result,
    input logic             in_gate
);
    // R1: tick is a single-cycle strobe
    a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R5: enable pair always complementary
    a_r5_pair_complement: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_kn == !cnt_j);

    // R6: no second wrap while one is still pending
    a_r6_no_double_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && mid_wrap) |-> tick);

    // R6: a poll clears the flag unless a fresh wrap arrived
    a_r6_poll_clears: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!ovf_flag || $past(mid_wrap)));

    // R7: valid lasts one cycle
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R7: result holds outside the publishing cycle
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(result));

    // R9: a result is only published from an open gate
    a_r9_valid_from_gate: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(in_gate));
endmodule

bind freq_gate_core fgc_checker #(.RES_W(RES_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .mid_wrap(u_cnt.mid_wrap),
    .ovf_flag(u_cnt.ovf_q),
    .cnt_j   (cnt_j),
    .cnt_kn  (cnt_kn),
    .valid   (result_valid),
    .result  (result),
    .in_gate (u_fsm.state_q == fgc_pkg::S_GATE)
);

// File: tb/freq_gate_core_bench.sv
module freq_gate_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CPT = 8;
    localparam int D0 = 3, D1 = 4, D2 = 6;
    localparam int P0 = 2, P1 = 5, P2 = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        edge_in = 1'b0;
    logic [1:0]  res_sel = 2'd0;
    logic        pre_mode = 1'b0;
    logic [31:0] result;
    logic        result_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    freq_gate_core #(
        .CLK_PER_TICK(CPT), .FAST_W(2), .MID_W(6), .EXT_BYTES(4), .RES_W(32),
        .DIR_LEN0(D0), .DIR_LEN1(D1), .DIR_LEN2(D2),
        .PRE_LEN0(P0), .PRE_LEN1(P1), .PRE_LEN2(P2)
    ) u_freq_gate_core (
        .clk(clk), .rst_n(rst_n), .edge_in(edge_in), .res_sel(res_sel),
        .pre_mode(pre_mode), .result(result), .result_valid(result_valid)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R10";
    bit done = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int len_of(int cfg);
        case (cfg)
            0: return D0;
            1: return D1;
            2, 3: return D2;
            4: return P0;
            5: return P1;
            default: return P2;
        endcase
    endfunction

    // behavioural reference
    int m_c = 0, m_tk = 0, m_state = 0, m_cfg = 0;
    bit m_en = 0;
    logic [31:0] m_acc = 0, exp_res = 0;
    bit exp_valid = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_c = 0; m_tk = 0; m_state = 0; m_cfg = 0; m_en = 0;
            m_acc = 0; exp_res = 0; exp_valid = 0;
        end else begin
            bit t;
            int cfg_now;
            t = (m_c == CPT - 1);
            cfg_now = int'(pre_mode) * 4 + int'(res_sel);
            exp_valid = 0;
            if (m_state == 0 || m_state == 2) begin
                if (t) begin m_state = 1; m_cfg = cfg_now; m_tk = 0; m_acc = 0; end
            end else begin
                if (cfg_now != m_cfg) m_state = 2;
                else if (t) begin
                    if (m_tk == len_of(m_cfg) - 1) begin
                        exp_valid = 1; exp_res = m_acc; m_acc = 0; m_tk = 0;
                    end else m_tk++;
                end
            end
            if (m_en && edge_in) m_acc++;
            m_en = 1;
            m_c = t ? 0 : m_c + 1;
        end
    end

    int cyc = 0, last_v = -1, spacing = 0, run_v = 0, max_run = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            chk({phase, " R7 valid"}, 32'(result_valid), 32'(exp_valid));
            chk({phase, " R5 result"}, result, exp_res);
            if (result_valid) begin
                if (last_v >= 0) spacing = cyc - last_v;
                last_v = cyc;
                run_v++;
                if (run_v > max_run) max_run = run_v;
            end else run_v = 0;
        end
    end

    task automatic run(int cycles, int sel, int pre, int density);
        @(negedge clk);
        res_sel = 2'(sel);
        pre_mode = 1'(pre);
        for (int i = 0; i < cycles; i++) begin
            edge_in = (($urandom % 100) < density);
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset result", result, 32'd0);
        chk("R10 reset valid", 32'(result_valid), 32'd0);
        rst_n = 1'b1;
        phase = "R10";
        run(30, 0, 0, 50);
        phase = "R2";
        run(100, 0, 0, 60);
        run(140, 1, 0, 30);
        run(200, 2, 0, 80);
        phase = "R3";
        run(80, 0, 1, 50);
        run(160, 1, 1, 70);
        run(220, 2, 1, 40);
        phase = "R4";
        run(200, 3, 0, 55);
        run(220, 3, 1, 65);
        phase = "R9";
        for (int k = 0; k < 12; k++) run(7 + k, k % 4, (k / 4) % 2, 50);
        run(60, 1, 0, 50);
        phase = "R6";
        run(1600, 0, 1, 100);
        run(800, 2, 0, 95);
        phase = "R8";
        run(200, 0, 0, 100);
        chk("R1 pulse spacing", 32'(spacing), 32'(D0 * CPT));
        chk("R8 continuous gate count", result, 32'(D0 * CPT));
        chk("R7 pulse width", 32'(max_run), 32'd1);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end
endmodule